// File: doc/BRIEF.md
# Clock Mismatch Detect-and-Latch Chain

This block guards a row of physically adjacent clock buffers during manufacturing test. Each neighbouring pair of buffer outputs feeds one comparison cell, so a row of `NUM_BUF` buffers uses `NUM_BUF-1` cells. When test checking is armed and a pair stays different for longer than a skew window, the cell latches a disable onto the enable of the second buffer of the pair. That buffer's output then sits at constant zero.

A buffer held at zero no longer matches its still-toggling neighbour, so the next cell also trips. The disable walks down the row until every clock from the faulty one to the last one is stuck low. A small duty-cycle fault, which a stuck-at pattern would normally miss, becomes a broad stuck-at-0 that an ordinary pattern can catch.

Checking is armed only when the test enable and the calibration-complete flag are both high. The clocks are modelled as levels sampled by a faster system clock `clk`. Each buffer is a one-cycle register gated by its enable. Buffer 0 is the reference and is never disabled. A status output reports the lowest disabled buffer.

Top module: `clkchain_guard`

## Requirements
- R1: While `rst_n` is low and at the first sample after its release, every bit of `buf_en` is 1, every bit of `buf_ck` is 0, `any_off` is 0 and `first_off` is 0.
- R2: Checking is armed only when `test_en` and `cal_done` are both 1. If either is 0, no enable is ever driven low, whatever the clocks do.
- R3: At each `clk` edge, `buf_ck[i]` takes `raw_ck[i]` if `buf_en[i]` was 1 at that edge, and takes 0 otherwise. A disabled buffer therefore stays at 0 from the edge after its enable falls.
- R4: A difference between `buf_ck[i]` and `buf_ck[i+1]` that lasts at most `SKEW_WIN` consecutive samples leaves every enable high.
- R5: While armed, a difference that lasts `SKEW_WIN+1` consecutive samples clears `buf_en[i+1]` at the edge that takes the last of those samples.
- R6: A disabled buffer trips the next cell, so every buffer from the first disabled one to the last ends up disabled. A fault on clock k≥1 gives `first_off`=k. A fault on clock 0 gives `first_off`=1, because `buf_en[0]` is always 1.
- R7: A cleared enable stays 0 for as long as checking stays armed, even after the clocks agree again.
- R8: An edge at which the block is not armed sets every enable to 1 and restarts every mismatch count. If a latch would set at that same edge, the clear wins.
- R9: `first_off` is the lowest index with `buf_en` at 0, and `any_off` is 1 exactly when some enable is 0. When no enable is 0, `first_off` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_en | input | 1 | Test-mode checking request |
| cal_done | input | 1 | Deskew calibration has finished |
| raw_ck | input | NUM_BUF | Sampled clocks entering the buffers |
| buf_ck | output | NUM_BUF | Gated buffer outputs |
| buf_en | output | NUM_BUF | Buffer enables, 0 = held low |
| first_off | output | $clog2(NUM_BUF) | Lowest disabled buffer index |
| any_off | output | 1 | Some buffer is disabled |

## Verification
The two functions that can fall on the same edge are the latch setting, when a mismatch count reaches its limit, and the clear caused by the block leaving the armed state. The bench drives the raw clocks directly, with one clock held high, and counts edges to the fourth mismatching sample. It drops `cal_done` just before that edge and expects every enable still high afterwards. It then re-arms and expects the latch to set exactly `SKEW_WIN+1` samples later, with `first_off` pointing at that buffer.

// File: rtl/ckc_pkg.sv
package ckc_pkg;

    // width of a counter that must reach win
    function automatic int unsigned cnt_width(input int unsigned win);
        return (win < 1) ? 1 : $clog2(win + 1);
    endfunction

    // width of a buffer index
    function automatic int unsigned idx_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/ckc_buffer.sv
module ckc_buffer (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    input  logic en,
    output logic ck_out
);

    typedef struct packed {
        logic ck;
    } buf_state_t;

    buf_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ck = raw_in & en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ck_out = st_q.ck;

endmodule

// File: rtl/ckc_cell.sv
module ckc_cell #(
    parameter int unsigned SKEW_WIN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic ck_a,
    input  logic ck_b,
    output logic off
);

    import ckc_pkg::*;

    localparam int unsigned CW = cnt_width(SKEW_WIN);
    localparam logic [CW-1:0] LIMIT = CW'(SKEW_WIN);

    typedef struct packed {
        logic [CW-1:0] run;
        logic          latched;
    } cell_state_t;

    cell_state_t st_d, st_q;
    logic        differ;

    assign differ = ck_a ^ ck_b;

    always_comb begin
        st_d = st_q;
        if (!arm) begin
            // leaving the armed state clears everything; wins over a set
            st_d.run     = '0;
            st_d.latched = 1'b0;
        end else if (!st_q.latched) begin
            if (differ) begin
                if (st_q.run == LIMIT) begin
                    st_d.latched = 1'b1;
                end else begin
                    st_d.run = st_q.run + 1'b1;
                end
            end else begin
                st_d.run = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign off = st_q.latched;

endmodule

// File: rtl/ckc_first_off.sv
module ckc_first_off #(
    parameter int unsigned NUM_BUF = 8
) (
    input  logic [NUM_BUF-1:0]                      en,
    output logic [ckc_pkg::idx_width(NUM_BUF)-1:0]  first,
    output logic                                    any
);

    localparam int unsigned IW = ckc_pkg::idx_width(NUM_BUF);

    always_comb begin
        first = '0;
        any   = 1'b0;
        for (int i = NUM_BUF - 1; i >= 0; i--) begin
            if (!en[i]) begin
                first = IW'(i);
                any   = 1'b1;
            end
        end
    end

endmodule

// File: rtl/clkchain_guard.sv
module clkchain_guard #(
    parameter int unsigned NUM_BUF  = 8,
    parameter int unsigned SKEW_WIN = 3
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    test_en,
    input  logic                                    cal_done,
    input  logic [NUM_BUF-1:0]                      raw_ck,
    output logic [NUM_BUF-1:0]                      buf_ck,
    output logic [NUM_BUF-1:0]                      buf_en,
    output logic [ckc_pkg::idx_width(NUM_BUF)-1:0]  first_off,
    output logic                                    any_off
);

    localparam int unsigned NUM_CELL = NUM_BUF - 1;

    logic               arm;
    logic [NUM_BUF-1:0] off;

    assign arm    = test_en & cal_done;
    assign off[0] = 1'b0;          // reference buffer is never gated
    assign buf_en = ~off;

    for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
        ckc_buffer u_buf (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_in (raw_ck[b]),
            .en     (buf_en[b]),
            .ck_out (buf_ck[b])
        );
    end

    for (genvar c = 0; c < NUM_CELL; c++) begin : g_cell
        ckc_cell #(
            .SKEW_WIN (SKEW_WIN)
        ) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .arm   (arm),
            .ck_a  (buf_ck[c]),
            .ck_b  (buf_ck[c+1]),
            .off   (off[c+1])
        );
    end

    ckc_first_off #(
        .NUM_BUF (NUM_BUF)
    ) u_first (
        .en    (buf_en),
        .first (first_off),
        .any   (any_off)
    );

endmodule

// File: rtl/ckc_guard_chk.sv
module ckc_guard_chk #(
    parameter int unsigned NUM_BUF = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               test_en,
    input logic               cal_done,
    input logic [NUM_BUF-1:0] buf_ck,
    input logic [NUM_BUF-1:0] buf_en,
    input logic               any_off
);

    // R2
    new_off_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~buf_en & $past(buf_en)) != '0) |-> $past(test_en && cal_done));

    // R8
    unarmed_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(test_en && cal_done) |=> (&buf_en));

    // R7
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && cal_done) |=> ((~$past(buf_en) & buf_en) == '0));

    // R3
    gated_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((buf_ck & ~$past(buf_en)) == '0));

    // R6
    ref_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_en[0]);

    // R9
    any_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_off == !(&buf_en));

endmodule

bind clkchain_guard ckc_guard_chk #(
    .NUM_BUF (NUM_BUF)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .test_en  (test_en),
    .cal_done (cal_done),
    .buf_ck   (buf_ck),
    .buf_en   (buf_en),
    .any_off  (any_off)
);

// File: tb/clkchain_guard_tb.sv
`timescale 1ns/1ps
module clkchain_guard_tb;

    localparam int NB  = 8;
    localparam int WIN = 3;
    localparam int PER = 16;
    localparam int IW  = $clog2(NB);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          test_en = 1'b0;
    logic          cal_done = 1'b0;
    logic [NB-1:0] raw_ck = '0;
    logic [NB-1:0] buf_ck, buf_en;
    logic [IW-1:0] first_off;
    logic          any_off;

    clkchain_guard #(.NUM_BUF(NB), .SKEW_WIN(WIN)) u_dut (
        .clk(clk), .rst_n(rst_n), .test_en(test_en), .cal_done(cal_done),
        .raw_ck(raw_ck), .buf_ck(buf_ck), .buf_en(buf_en),
        .first_off(first_off), .any_off(any_off)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    int f_idx = 15, f_high = PER / 2, s_idx = 15, s_dly = 0, ph = 0;
    bit manual = 1'b1;

    // vector: enables, faulty clock and its high time, skewed clock and delay, expectation
    typedef struct packed {
        logic       te;
        logic       cal;
        logic [3:0] fi;
        logic [4:0] fh;
        logic [3:0] si;
        logic [3:0] sd;
        logic       ex_any;
        logic [2:0] ex_first;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b1, 4'd15, 5'd8,  4'd15, 4'd0, 1'b0, 3'd0}, // clean
        '{1'b1, 1'b1, 4'd3,  5'd13, 4'd15, 4'd0, 1'b1, 3'd3}, // long high on 3
        '{1'b1, 1'b1, 4'd0,  5'd14, 4'd15, 4'd0, 1'b1, 3'd1}, // fault on reference
        '{1'b1, 1'b1, 4'd7,  5'd3,  4'd15, 4'd0, 1'b1, 3'd7}, // short high on last
        '{1'b1, 1'b1, 4'd15, 5'd8,  4'd5,  4'd3, 1'b0, 3'd0}, // skew at window
        '{1'b1, 1'b1, 4'd15, 5'd8,  4'd5,  4'd4, 1'b1, 3'd5}, // skew past window
        '{1'b1, 1'b0, 4'd3,  5'd13, 4'd15, 4'd0, 1'b0, 3'd0}, // not calibrated
        '{1'b0, 1'b1, 4'd3,  5'd13, 4'd15, 4'd0, 1'b0, 3'd0}, // test off
        '{1'b1, 1'b1, 4'd6,  5'd12, 4'd15, 4'd0, 1'b1, 3'd6}, // window+1 distortion
        '{1'b1, 1'b1, 4'd2,  5'd11, 4'd15, 4'd0, 1'b0, 3'd0}, // window distortion
        '{1'b1, 1'b1, 4'd15, 5'd8,  4'd0,  4'd4, 1'b1, 3'd1}  // reference skewed
    };

    function automatic logic gen(input int k);
        int h, d;
        h = (k == f_idx) ? f_high : PER / 2;
        d = (k == s_idx) ? s_dly : 0;
        return ((ph - d + PER) % PER) < h;
    endfunction

    initial begin
        forever begin
            @(negedge clk);
            ph = (ph + 1) % PER;
            if (!manual) begin
                for (int k = 0; k < NB; k++) raw_ck[k] = gen(k);
            end
        end
    end

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    logic [NB-1:0] exp_en, prev;
    bit ok;

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        check(buf_en === '1 && buf_ck === '0, "R1 in reset en/ck", {buf_en, buf_ck}, {8'hFF, 8'h00});
        rst_n = 1'b1;
        @(negedge clk);
        check(buf_en === '1 && any_off === 1'b0 && first_off === '0, "R1 after release",
              {buf_en, 7'd0, any_off, 5'd0, first_off}, {8'hFF, 16'h0});

        // vector table
        manual = 1'b0;
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            test_en = 1'b0;
            cal_done = 1'b0;
            f_idx = VEC[v].fi;
            f_high = VEC[v].fh;
            s_idx = VEC[v].si;
            s_dly = VEC[v].sd;
            repeat (3) @(negedge clk);
            test_en = VEC[v].te;
            cal_done = VEC[v].cal;
            repeat (24 * PER) @(negedge clk);
            exp_en = '1;
            if (VEC[v].ex_any) begin
                for (int k = 0; k < NB; k++) if (k >= VEC[v].ex_first) exp_en[k] = 1'b0;
            end
            check(buf_en === exp_en, $sformatf("R2/R4/R5/R6 vec %0d enables", v), buf_en, exp_en);
            check(any_off === VEC[v].ex_any && first_off === VEC[v].ex_first,
                  $sformatf("R9 vec %0d status", v), {any_off, first_off}, {VEC[v].ex_any, VEC[v].ex_first});
            ok = 1'b1;
            repeat (PER) begin
                @(posedge clk);
                #1 prev = raw_ck;
                @(negedge clk);
                if (buf_ck !== (prev & exp_en)) ok = 1'b0;
            end
            check(ok, $sformatf("R3 vec %0d gated outputs", v), buf_ck, prev & exp_en);
        end

        // directed: clear and set on the same edge, then exact latch timing
        manual = 1'b1;
        @(negedge clk);
        test_en = 1'b0;
        raw_ck = '0;
        repeat (3) @(negedge clk);
        test_en = 1'b1;
        cal_done = 1'b1;
        @(negedge clk);
        raw_ck = 8'b0000_0100;
        repeat (4) @(posedge clk);       // edges E0..E3
        @(negedge clk);
        cal_done = 1'b0;                 // clear lands on E4, the would-be set edge
        @(posedge clk);
        @(negedge clk);
        check(buf_en === '1, "R8 clear beats set", buf_en, 8'hFF);
        cal_done = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(buf_en === '1, "R4 window samples only", buf_en, 8'hFF);
        @(posedge clk);
        @(negedge clk);
        check(buf_en === 8'hF3, "R5 latch on window+1 sample", buf_en, 8'hF3);
        check(first_off === 3'd2 && any_off === 1'b1, "R9 directed status", {any_off, first_off}, 4'hA);

        // R7: hold after the clocks agree again
        raw_ck = '0;
        repeat (10) @(negedge clk);
        check(buf_en === 8'hF3, "R7 latch held", buf_en, 8'hF3);
        cal_done = 1'b0;
        @(negedge clk);
        check(buf_en === '1 && any_off === 1'b0, "R8 clear on disarm", buf_en, 8'hFF);

        finish_run();
    end

endmodule